// File: doc/BRIEF.md
# APB Register and Switch Peripheral

This block is an APB completer that occupies a 16-byte window. It holds two 32-bit control registers that the bus master can write, and it reports the levels of two switch inputs when the master reads. Each direction reaches a different resource at the same offset. A write to the first word loads control register A, and a read of that word returns switch A. The second word behaves the same way, with control register B and switch B. Bit 0 of control register A drives an LED output. Both control registers are also exported whole, so that neighbouring logic can use them.

The completer never inserts wait states and never reports an error. Every transfer therefore finishes in its first access cycle. Offsets are decoded from the low 8 address bits only, and the upper address bits have no effect. The switch inputs are asynchronous to the bus clock, so they pass through a two-flop synchronizer before they reach the read data. An active-low asynchronous reset clears both control registers, and with them the LED.

Top module: `apb_sw_periph`

## Requirements
- R1: While rst_ni is low, ctrl_a_o, ctrl_b_o and led_o are all zero, and they stay zero until the first write after reset.
- R2: On a rising clk_i edge with psel_i, penable_i and pwrite_i all high and paddr_i[7:0] == 8'h00, ctrl_a_o takes the value of pwdata_i.
- R3: On a rising clk_i edge with psel_i, penable_i and pwrite_i all high and paddr_i[7:0] == 8'h04, ctrl_b_o takes the value of pwdata_i.
- R4: If any one of psel_i, penable_i or pwrite_i is low at an edge, neither control register changes. This covers the setup cycle, deselected cycles and reads.
- R5: Only paddr_i[7:0] selects the offset. paddr_i[31:8] has no effect on writes or reads.
- R6: Every 8-bit offset other than 8'h00 and 8'h04 is unmapped, including 8'h08 and 8'h0C. A write there changes no register, and a read there returns zero.
- R7: A read (psel_i high, pwrite_i low) at offset 8'h00 returns synchronized sw_i[0] in prdata_o[0]. At offset 8'h04 it returns synchronized sw_i[1] in prdata_o[0]. prdata_o[31:1] is always zero.
- R8: A change on sw_i reaches prdata_o after exactly two rising clk_i edges. After one edge the read still returns the old level.
- R9: pready_o is always 1 and pslverr_o is always 0.
- R10: led_o equals bit 0 of ctrl_a_o at all times.
- R11: prdata_o is zero whenever psel_i is low or pwrite_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | Completer select |
| penable_i | input | 1 | Access-phase marker |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 32 | Byte address; only bits 7:0 are decoded |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data |
| pready_o | output | 1 | Always ready |
| pslverr_o | output | 1 | Never an error |
| sw_i | input | 2 | Asynchronous switch levels; bit 0 = switch A, bit 1 = switch B |
| led_o | output | 1 | LED drive, bit 0 of control register A |
| ctrl_a_o | output | 32 | Control register A contents |
| ctrl_b_o | output | 32 | Control register B contents |

## Verification
The hardest behaviour to observe from the ports is the synchronizer latency. A read is normally a short two-cycle event, so a switch change during a transfer is easy to miss. The stimulus therefore holds a read of offset 0 open across the change. It samples prdata_o in the middle of each following cycle, and it checks that the old level remains after one edge and that the new level appears after the second. Write decode is covered by a sweep over all 256 low-address values. Each write uses a distinct data word and alternates between two upper-address patterns. Every write is followed by a comparison of both control registers against a model kept in the bench.

// File: rtl/apb_sw_pkg.sv
`timescale 1ns/1ps
package apb_sw_pkg;
  localparam int unsigned NUM_CH    = 2;  // register/switch pairs
  localparam int unsigned WORD_STEP = 4;  // byte stride between words

  function automatic int unsigned ch_offset(int unsigned idx);
    return idx * WORD_STEP;
  endfunction
endpackage

// File: rtl/apb_sw_wdec.sv
`timescale 1ns/1ps
module apb_sw_wdec
  import apb_sw_pkg::*;
#(
  parameter int unsigned DEC_W = 8
) (
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [DEC_W-1:0]  off_i,
  output logic [NUM_CH-1:0] we_o
);
  logic wr_access;
  assign wr_access = psel_i & penable_i & pwrite_i;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_we
    assign we_o[i] = wr_access && (off_i == DEC_W'(ch_offset(i)));
  end
endmodule

// File: rtl/apb_sw_sync.sv
`timescale 1ns/1ps
module apb_sw_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/apb_sw_rmux.sv
`timescale 1ns/1ps
module apb_sw_rmux
  import apb_sw_pkg::*;
#(
  parameter int unsigned DEC_W  = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              psel_i,
  input  logic              pwrite_i,
  input  logic [DEC_W-1:0]  off_i,
  input  logic [NUM_CH-1:0] sw_sync_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (psel_i && !pwrite_i) begin
      for (int unsigned i = 0; i < NUM_CH; i++) begin
        if (off_i == DEC_W'(ch_offset(i))) rdata_o[0] = sw_sync_i[i];
      end
    end
  end
endmodule

// File: rtl/apb_sw_periph.sv
`timescale 1ns/1ps
module apb_sw_periph
  import apb_sw_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned DEC_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  input  logic [NUM_CH-1:0] sw_i,
  output logic              led_o,
  output logic [DATA_W-1:0] ctrl_a_o,
  output logic [DATA_W-1:0] ctrl_b_o
);
  logic [DEC_W-1:0]  off;
  logic              unused_addr_hi;
  logic [NUM_CH-1:0] we;
  logic [NUM_CH-1:0] sw_sync;
  logic [DATA_W-1:0] regs_q [NUM_CH];

  assign off            = paddr_i[DEC_W-1:0];
  assign unused_addr_hi = ^paddr_i[ADDR_W-1:DEC_W];

  apb_sw_wdec #(.DEC_W(DEC_W)) u_wdec (
    .psel_i   (psel_i),
    .penable_i(penable_i),
    .pwrite_i (pwrite_i),
    .off_i    (off),
    .we_o     (we)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   regs_q[i] <= '0;
      else if (we[i]) regs_q[i] <= pwdata_i;
    end
  end

  apb_sw_sync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_CH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sw_i),
    .q_o   (sw_sync)
  );

  apb_sw_rmux #(.DEC_W(DEC_W), .DATA_W(DATA_W)) u_rmux (
    .psel_i   (psel_i),
    .pwrite_i (pwrite_i),
    .off_i    (off),
    .sw_sync_i(sw_sync),
    .rdata_o  (prdata_o)
  );

  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;
  assign ctrl_a_o  = regs_q[0];
  assign ctrl_b_o  = regs_q[1];
  assign led_o     = regs_q[0][0];
endmodule

// File: rtl/apb_sw_chk.sv
`timescale 1ns/1ps
module apb_sw_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              psel_i,
  input logic              penable_i,
  input logic              pwrite_i,
  input logic [ADDR_W-1:0] paddr_i,
  input logic [DATA_W-1:0] pwdata_i,
  input logic [DATA_W-1:0] prdata_o,
  input logic [1:0]        sw_i,
  input logic [DATA_W-1:0] ctrl_a_o,
  input logic [DATA_W-1:0] ctrl_b_o
);
  logic [1:0] since_rst;
  logic [7:0] off;
  logic       mapped;
  logic       wr_acc;
  logic       rd;

  assign off    = paddr_i[7:0];
  assign mapped = (off == 8'h00) || (off == 8'h04);
  assign wr_acc = psel_i && penable_i && pwrite_i;
  assign rd     = psel_i && !pwrite_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_A_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && off == 8'h00) |=> ctrl_a_o == $past(pwdata_i)); // R2
  AST_B_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && off == 8'h04) |=> ctrl_b_o == $past(pwdata_i)); // R3
  AST_NO_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_acc |=> ($stable(ctrl_a_o) && $stable(ctrl_b_o))); // R4
  AST_UNMAPPED_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |=> ($stable(ctrl_a_o) && $stable(ctrl_b_o))); // R6
  AST_UNMAPPED_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !mapped) |-> prdata_o == '0); // R6
  AST_RD_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prdata_o[DATA_W-1:1] == '0); // R7
  AST_SYNC_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3 && rd && off == 8'h00) |-> prdata_o[0] == $past(sw_i[0], 2)); // R8
  AST_IDLE_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |-> prdata_o == '0); // R11
endmodule

bind apb_sw_periph apb_sw_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .psel_i   (psel_i),
  .penable_i(penable_i),
  .pwrite_i (pwrite_i),
  .paddr_i  (paddr_i),
  .pwdata_i (pwdata_i),
  .prdata_o (prdata_o),
  .sw_i     (sw_i),
  .ctrl_a_o (ctrl_a_o),
  .ctrl_b_o (ctrl_b_o)
);

// File: tb/sim_apb_sw_periph.sv
`timescale 1ns/1ps
module sim_apb_sw_periph;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [31:0] paddr = '0, pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, led;
  logic [1:0]  sw = 2'b00;
  logic [31:0] ctrl_a, ctrl_b;
  logic [31:0] exp_a = '0, exp_b = '0;
  int          n_chk = 0, n_bad = 0;
  logic [31:0] rd_val;

  always #10 clk = ~clk; // 50 MHz

  apb_sw_periph u0 (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata),
    .prdata_o(prdata), .pready_o(pready), .pslverr_o(pslverr),
    .sw_i(sw), .led_o(led), .ctrl_a_o(ctrl_a), .ctrl_b_o(ctrl_b)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    check(req, ctrl_a, exp_a);
    check(req, ctrl_b, exp_b);
    check({req, "/R10"}, {31'd0, led}, {31'd0, exp_a[0]});
    check({req, "/R9"}, {30'd0, pready, pslverr}, 32'd2);
  endtask

  task automatic apb_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    #2 check("R11 write access", prdata, 32'd0);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    case (a[7:0])
      8'h00:   exp_a = d;
      8'h04:   exp_b = d;
      default: ;
    endcase
  endtask

  task automatic apb_read(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #2 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  function automatic logic [31:0] exp_rd(input logic [7:0] off, input logic [1:0] s);
    if (off == 8'h00) return {31'd0, s[0]};
    if (off == 8'h04) return {31'd0, s[1]};
    return 32'd0;
  endfunction

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    #35;
    check_regs("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_regs("R1 after release");

    // R2/R3/R5/R6: full sweep of low address byte, two upper patterns
    for (int i = 0; i < 256; i++) begin
      logic [31:0] base;
      base = (i % 2 == 0) ? 32'h0000_1000 : 32'hFFFF_FF00;
      apb_write(base | 32'(i), {8'(i), ~8'(i), 8'(i) ^ 8'h5A, 8'h3C} + 32'(i));
      check_regs((i == 0) ? "R2 R5" : (i == 4) ? "R3 R5" : "R6 unmapped write");
    end

    // R4: setup phase only, deselected access, read access
    apb_write(32'h0000_1000, 32'hA5A5_0001);
    apb_write(32'h0000_1004, 32'h1234_5678);
    check_regs("R2 R3 reload");
    @(negedge clk); psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 32'h0; pwdata = 32'h0;
    repeat (2) @(negedge clk);
    psel = 1'b0;
    check_regs("R4 setup only");
    penable = 1'b1; pwrite = 1'b1; paddr = 32'h4; pwdata = 32'hDEAD_BEEF;
    repeat (2) @(negedge clk);
    penable = 1'b0; pwrite = 1'b0;
    check_regs("R4 psel low");
    apb_read(32'h0000_1000, rd_val);
    apb_read(32'h0000_1004, rd_val);
    check_regs("R4 read");
    #2 check("R11 idle", prdata, 32'd0);

    // R7/R5/R6: every switch pattern, every low address byte
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); sw = 2'(s);
      repeat (3) @(negedge clk);
      for (int i = 0; i < 256; i++) begin
        apb_read(((i % 2 == 0) ? 32'h0000_1000 : 32'h7654_3200) | 32'(i), rd_val);
        check((i == 0 || i == 4) ? "R7 R5 read" : "R6 unmapped read",
              rd_val, exp_rd(8'(i), 2'(s)));
      end
      check_regs("R7 no side effect");
    end

    // R8: hold a read of offset 0 open across a switch change
    @(negedge clk); sw = 2'b00;
    repeat (3) @(negedge clk);
    psel = 1'b1; penable = 1'b1; pwrite = 1'b0; paddr = 32'h0000_1000;
    #2 check("R8 settled", prdata, 32'd0);
    @(negedge clk); sw = 2'b01;
    #2 check("R8 zero edges", prdata, 32'd0);
    @(negedge clk);
    #2 check("R8 one edge", prdata, 32'd0);
    @(negedge clk);
    #2 check("R8 two edges", prdata, 32'd1);
    paddr = 32'h0000_1004;
    @(negedge clk); sw = 2'b10;
    @(negedge clk);
    #2 check("R8 B one edge", prdata, 32'd0);
    @(negedge clk);
    #2 check("R8 B two edges", prdata, 32'd1);
    psel = 1'b0; penable = 1'b0;

    // R1: reset in mid-run clears registers
    apb_write(32'h0000_1000, 32'hFFFF_FFFF);
    apb_write(32'h0000_1004, 32'h0F0F_0F0F);
    check_regs("R1 preload");
    @(negedge clk); rst_n = 1'b0;
    exp_a = '0; exp_b = '0;
    #2 check_regs("R1 async reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_regs("R1 after second release");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule